// File: doc/BRIEF.md
# Recorder Power-State Sequencer

This block supervises a battery-powered transient recorder. It walks the recorder through a fixed mission cycle of five operating states and, in each one, releases only those voltage regulators whose rails the state needs. Every other regulator is held in shutdown to save battery charge. A regulator's output is live only while its enable line is driven high.

After reset the block reads a 4-bit switch code once. It then waits for an arming delay that is counted in ticks of a separate, slow timebase, nominally 1 MHz. The tick arrives asynchronously to the fast master clock and is synchronised before use. When the delay has run out, the block powers the acquisition rails and waits for a trigger. A trigger starts recording. The end of capture moves the block to a low-power hold. A host read request opens a readout, and read completion returns the block to hold.

A status LED shows progress in the field. It blinks while the block waits for a trigger and is lit steadily while data is held.

Top module: `rec_power_seq`

## Requirements
- R1: While reset is asserted and right after it is released, `state_o` is 0 (delay), all three enables are low and `led_o` is low.
- R2: `dip_i` is captured on the first clock edge after reset is released. Any later change to `dip_i` leaves the arming delay unchanged until the next reset.
- R3: With captured code n, the state stays at 0 (delay) until exactly (n+1)·UNIT_TICKS timebase ticks have been counted. The state then becomes 1 (armed) and leaves that state only on a trigger.
- R4: The asynchronous `tick_i` counts once per rising edge, however long it stays high.
- R5: In state 1, `trig_i` high at a clock edge moves the state to 2 (recording) at that edge. In every other state `trig_i` has no effect.
- R6: In state 2, `cap_done_i` high moves the state to 3 (hold). In every other state it has no effect.
- R7: In state 3, `rd_req_i` high moves the state to 4 (readout). In every other state it has no effect.
- R8: In state 4, `rd_done_i` high returns the state to 3. In every other state it has no effect.
- R9: The enables `en_analog_o`, `en_mem_o` and `en_host_o` follow the state:
  - delay: 0,0,0
  - armed: 1,1,0
  - recording: 1,1,0
  - hold: 0,1,0
  - readout: 0,1,1
- R10: `led_o` is steadily high in state 3. In state 1 it starts low on entry and toggles after every BLINK_HALF ticks. In all other states it is low.
- R11: `state_o` only ever takes the values 0 to 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low reset |
| tick_i | input | 1 | Slow timebase tick, asynchronous |
| dip_i | input | 4 | Arming delay code from the switches |
| trig_i | input | 1 | Trigger detected |
| cap_done_i | input | 1 | Capture finished |
| rd_req_i | input | 1 | Host asks to read |
| rd_done_i | input | 1 | Host read finished |
| en_analog_o | output | 1 | Converter and analog regulator enable |
| en_mem_o | output | 1 | Memory regulator enable |
| en_host_o | output | 1 | Host interface regulator enable |
| state_o | output | 3 | Current state code |
| led_o | output | 1 | Status LED |

## Verification
A control input that is high at a clock edge changes `state_o` and the three enables at that same edge. The bench therefore drives each input on a falling edge and reads the result on the next falling edge. A tick reaches the counters two master-clock edges after its rise, and the resulting expiry takes two more edges to show up in the state. Each bench tick is held high for four cycles and low for four, so every count and every state change has settled before the bench samples at the end of a tick. The delay, LED and long-tick checks all sample at tick boundaries in this way.

// File: rtl/rps_pkg.sv
package rps_pkg;

    typedef enum logic [2:0] {
        ST_DELAY   = 3'd0,
        ST_ARMED   = 3'd1,
        ST_RECORD  = 3'd2,
        ST_HOLD    = 3'd3,
        ST_READOUT = 3'd4
    } rps_state_e;

    typedef struct packed {
        logic analog;
        logic mem;
        logic host;
    } rps_rails_t;

    function automatic rps_rails_t rails_for(rps_state_e s);
        rps_rails_t r;
        r = '0;
        case (s)
            ST_ARMED:   begin r.analog = 1'b1; r.mem = 1'b1; end
            ST_RECORD:  begin r.analog = 1'b1; r.mem = 1'b1; end
            ST_HOLD:    r.mem = 1'b1;
            ST_READOUT: begin r.mem = 1'b1; r.host = 1'b1; end
            default:    r = '0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/rps_tick_sync.sv
module rps_tick_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    output logic pulse_o
);
    localparam int CHAIN_W = SYNC_STAGES + 1;

    logic [CHAIN_W-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[CHAIN_W-2:0], tick_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    // one pulse per rising edge of the synchronised tick
    assign pulse_o = chain_q[SYNC_STAGES-1] & ~chain_q[SYNC_STAGES];
endmodule

// File: rtl/rps_arm_timer.sv
module rps_arm_timer #(
    parameter int CODE_W     = 4,
    parameter int UNIT_TICKS = 60_000_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [CODE_W-1:0] code_i,
    input  logic              tick_i,
    output logic              done_o
);
    localparam int SUB_W = $clog2(UNIT_TICKS + 1);
    localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(UNIT_TICKS - 1);

    typedef struct packed {
        logic              running;
        logic              done;
        logic [CODE_W-1:0] units_left;
        logic [SUB_W-1:0]  sub;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (load_i) begin
            tmr_d.running    = 1'b1;
            tmr_d.done       = 1'b0;
            tmr_d.units_left = code_i;
            tmr_d.sub        = '0;
        end else if (tmr_q.running && tick_i) begin
            if (tmr_q.sub == SUB_LAST) begin
                tmr_d.sub = '0;
                if (tmr_q.units_left == '0) begin
                    tmr_d.running = 1'b0;
                    tmr_d.done    = 1'b1;
                end else begin
                    tmr_d.units_left = tmr_q.units_left - 1'b1;
                end
            end else begin
                tmr_d.sub = tmr_q.sub + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign done_o = tmr_q.done;
endmodule

// File: rtl/rps_status_led.sv
module rps_status_led #(
    parameter int BLINK_HALF = 500_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic blink_en_i,
    input  logic steady_i,
    input  logic tick_i,
    output logic led_o
);
    localparam int CNT_W = $clog2(BLINK_HALF + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BLINK_HALF - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             phase;
    } blink_t;

    blink_t bl_d, bl_q;

    always_comb begin
        bl_d = bl_q;
        if (!blink_en_i) begin
            bl_d.cnt   = '0;
            bl_d.phase = 1'b0;
        end else if (tick_i) begin
            if (bl_q.cnt == CNT_LAST) begin
                bl_d.cnt   = '0;
                bl_d.phase = ~bl_q.phase;
            end else begin
                bl_d.cnt = bl_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bl_q <= '0;
        else        bl_q <= bl_d;
    end

    assign led_o = steady_i | (blink_en_i & bl_q.phase);
endmodule

// File: rtl/rec_power_seq.sv
module rec_power_seq
    import rps_pkg::*;
#(
    parameter int CODE_W      = 4,
    parameter int UNIT_TICKS  = 60_000_000,
    parameter int BLINK_HALF  = 500_000,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic [CODE_W-1:0] dip_i,
    input  logic              trig_i,
    input  logic              cap_done_i,
    input  logic              rd_req_i,
    input  logic              rd_done_i,
    output logic              en_analog_o,
    output logic              en_mem_o,
    output logic              en_host_o,
    output logic [2:0]        state_o,
    output logic              led_o
);
    typedef struct packed {
        rps_state_e state;
        rps_rails_t rails;
        logic       loaded;
    } seq_t;

    seq_t seq_d, seq_q;
    logic tick_pulse;
    logic delay_done;

    rps_tick_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (tick_i),
        .pulse_o (tick_pulse)
    );

    rps_arm_timer #(.CODE_W(CODE_W), .UNIT_TICKS(UNIT_TICKS)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (~seq_q.loaded),
        .code_i (dip_i),
        .tick_i (tick_pulse),
        .done_o (delay_done)
    );

    rps_status_led #(.BLINK_HALF(BLINK_HALF)) u_led (
        .clk        (clk),
        .rst_n      (rst_n),
        .blink_en_i (seq_q.state == ST_ARMED),
        .steady_i   (seq_q.state == ST_HOLD),
        .tick_i     (tick_pulse),
        .led_o      (led_o)
    );

    always_comb begin
        seq_d        = seq_q;
        seq_d.loaded = 1'b1;
        case (seq_q.state)
            ST_DELAY:   if (delay_done) seq_d.state = ST_ARMED;
            ST_ARMED:   if (trig_i)     seq_d.state = ST_RECORD;
            ST_RECORD:  if (cap_done_i) seq_d.state = ST_HOLD;
            ST_HOLD:    if (rd_req_i)   seq_d.state = ST_READOUT;
            ST_READOUT: if (rd_done_i)  seq_d.state = ST_HOLD;
            default:                    seq_d.state = ST_DELAY;
        endcase
        seq_d.rails = rails_for(seq_d.state);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q.state  <= ST_DELAY;
            seq_q.rails  <= '0;
            seq_q.loaded <= 1'b0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign en_analog_o = seq_q.rails.analog;
    assign en_mem_o    = seq_q.rails.mem;
    assign en_host_o   = seq_q.rails.host;
    assign state_o     = seq_q.state;
endmodule

// File: rtl/rps_checker.sv
module rps_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       trig_i,
    input logic       cap_done_i,
    input logic       rd_req_i,
    input logic       rd_done_i,
    input logic       en_analog_o,
    input logic       en_mem_o,
    input logic       en_host_o,
    input logic [2:0] state_o,
    input logic       led_o
);
    p_state_legal_r11: assert property (@(posedge clk) disable iff (!rst_n)
        state_o <= 3'd4);

    p_rails_match_r9: assert property (@(posedge clk) disable iff (!rst_n)
        {en_analog_o, en_mem_o, en_host_o} ==
            ((state_o == 3'd0) ? 3'b000 :
             (state_o == 3'd1 || state_o == 3'd2) ? 3'b110 :
             (state_o == 3'd3) ? 3'b010 : 3'b011));

    p_delay_exit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd0) |=> (state_o == 3'd0 || state_o == 3'd1));

    p_trig_record_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd1 && trig_i) |=> state_o == 3'd2);

    p_capdone_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd2 && cap_done_i) |=> state_o == 3'd3);

    p_rdreq_readout_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd3 && rd_req_i) |=> state_o == 3'd4);

    p_rddone_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd4 && rd_done_i) |=> state_o == 3'd3);

    p_led_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd3) |-> led_o);

    p_led_dark_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd0 || state_o == 3'd2 || state_o == 3'd4) |-> !led_o);
endmodule

bind rec_power_seq rps_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .trig_i      (trig_i),
    .cap_done_i  (cap_done_i),
    .rd_req_i    (rd_req_i),
    .rd_done_i   (rd_done_i),
    .en_analog_o (en_analog_o),
    .en_mem_o    (en_mem_o),
    .en_host_o   (en_host_o),
    .state_o     (state_o),
    .led_o       (led_o)
);

// File: tb/sim_rec_power_seq.sv
module sim_rec_power_seq;
    localparam int UNIT = 2;
    localparam int HALF = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic [3:0] dip = 4'd0;
    logic       trig = 1'b0, cap = 1'b0, rreq = 1'b0, rdone = 1'b0;
    logic       ea, em, eh, led;
    logic [2:0] st;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    rec_power_seq #(.UNIT_TICKS(UNIT), .BLINK_HALF(HALF)) u0 (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .dip_i(dip),
        .trig_i(trig), .cap_done_i(cap), .rd_req_i(rreq), .rd_done_i(rdone),
        .en_analog_o(ea), .en_mem_o(em), .en_host_o(eh),
        .state_o(st), .led_o(led)
    );

    // {trig, cap, rreq, rdone, exp_state[2:0], exp_rails[2:0], exp_led}
    localparam int NV = 9;
    localparam logic [10:0] VEC [NV] = '{
        {4'b0111, 3'd1, 3'b110, 1'b0},  // R6 R7 R8 ignored while armed
        {4'b1000, 3'd2, 3'b110, 1'b0},  // R5 trigger
        {4'b1011, 3'd2, 3'b110, 1'b0},  // R7 R8 ignored while recording
        {4'b0100, 3'd3, 3'b010, 1'b1},  // R6 capture done
        {4'b1101, 3'd3, 3'b010, 1'b1},  // R5 R6 R8 ignored in hold
        {4'b0010, 3'd4, 3'b011, 1'b0},  // R7 read request
        {4'b1110, 3'd4, 3'b011, 1'b0},  // R5 R6 R7 ignored in readout
        {4'b0001, 3'd3, 3'b010, 1'b1},  // R8 read done
        {4'b0000, 3'd3, 3'b010, 1'b1}   // hold stays
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic [3:0] code);
        @(negedge clk);
        rst_n = 1'b0;
        dip = code;
        repeat (3) @(negedge clk);
        chk("R1 state in reset", st, 0);
        chk("R1 rails in reset", {ea, em, eh}, 0);
        chk("R1 led in reset", led, 0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic send_ticks(input int n, input int high = 4);
        for (int i = 0; i < n; i++) begin
            tick = 1'b1;
            repeat (high) @(negedge clk);
            tick = 1'b0;
            repeat (4) @(negedge clk);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R1 and R3: code 0 gives UNIT ticks
        do_reset(4'd0);
        chk("R1 state after release", st, 0);
        chk("R9 rails in delay", {ea, em, eh}, 0);
        trig = 1'b1;
        @(negedge clk);
        trig = 1'b0;
        chk("R5 trigger ignored in delay", st, 0);
        send_ticks(UNIT - 1);
        chk("R3 still delay one tick early", st, 0);
        send_ticks(1);
        chk("R3 armed at code 0 expiry", st, 1);
        chk("R9 rails armed", {ea, em, eh}, 3'b110);

        // R10 blink in armed
        chk("R10 led off on entry", led, 0);
        send_ticks(HALF - 1);
        chk("R10 led still off", led, 0);
        send_ticks(1);
        chk("R10 led toggled on", led, 1);
        send_ticks(HALF);
        chk("R10 led toggled off", led, 0);

        // vector table for R5-R9
        for (int v = 0; v < NV; v++) begin
            {trig, cap, rreq, rdone} = VEC[v][10:7];
            @(negedge clk);
            {trig, cap, rreq, rdone} = 4'b0;
            chk($sformatf("R11 state vec %0d", v), st, int'(VEC[v][6:4]));
            chk($sformatf("R9 rails vec %0d", v), {ea, em, eh}, int'(VEC[v][3:1]));
            chk($sformatf("R10 led vec %0d", v), led, int'(VEC[v][0]));
        end

        // R2: change switches after capture
        do_reset(4'd3);
        dip = 4'd0;
        send_ticks(4 * UNIT - 1);
        chk("R2 later switch change ignored", st, 0);
        send_ticks(1);
        chk("R2 captured code 3 delay", st, 1);

        // R3 upper boundary, code 15
        do_reset(4'd15);
        send_ticks(16 * UNIT - 1);
        chk("R3 code 15 one tick early", st, 0);
        send_ticks(1);
        chk("R3 code 15 expiry", st, 1);

        // R4: long tick counts once
        do_reset(4'd1);
        send_ticks(1, 30);
        send_ticks(2 * UNIT - 2);
        chk("R4 long tick counted once", st, 0);
        send_ticks(1);
        chk("R4 expiry after last tick", st, 1);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule